// File: doc/BRIEF.md
# Software (Xon/Xoff) Flow-Control Engine

This block sits between a UART receiver and its transmitter and handles in-band flow control. Every character the receiver delivers is compared with four programmable codes: two "resume" codes and two "stop" codes. Matching can use one character or a pair of back-to-back characters. A stop match holds the transmitter at the next character boundary and raises a status flag. A resume match releases the transmitter and clears the flag. Flow characters never reach the receive FIFO. Every other character is passed on through a push strobe with its data.

The block also watches the receive FIFO fill level. When the level rises above a high mark, it pulses a request for the transmitter to send a stop code. When the level later falls below a low mark, it pulses a request to send a resume code.

In a separate special-character mode, flow control is off. Each character is compared with the second stop code only. A match sets the flag, and the character is still pushed.

Top module: `xonxoff_flow_ctl`

## Requirements
- R1: With flow control on in single mode, a character equal to the first stop code (index 2 of the code write port) is not pushed, and the flag becomes 1 on the next clock edge.
- R2: `tx_pause` does not rise while `tx_busy` is high. It rises within two clocks after a stop match once `tx_busy` is low.
- R3: A character equal to the first resume code (index 0) is not pushed. It clears the flag and releases `tx_pause`.
- R4: Characters that match no code are pushed unchanged in the cycle they arrive. With flow control off, every character is pushed.
- R5: Only the low 5, 6, 7 or 8 bits take part in a comparison, selected by `word_len` = 0, 1, 2 or 3, with code bit 0 aligned to the received LSB.
- R6: In dual mode, a pair of back-to-back characters is recognised only as first code then second code (stop: index 2 then 3; resume: index 0 then 1). Neither character of a recognised pair is pushed.
- R7: In dual mode, when a first-code character is followed by a character that does not complete the pair, the held character is pushed in the second character's cycle. The second character is then re-checked one cycle later as a possible new first code. Received characters are at least two cycles apart.
- R8: In special mode, a character equal to the second stop code (index 3) is pushed and sets the flag, and `tx_pause` stays low.
- R9: `irq` equals the flag gated by `irq_en`. A `flag_clr` pulse clears the flag.
- R10: `send_xoff` pulses once per rise of `fifo_count` above `thr_hi`. `send_xon` pulses once when the count drops below `thr_lo`, and only after a `send_xoff`.
- R11: All four codes reset to zero. Code index 0 is resume-1, 1 is resume-2, 2 is stop-1 and 3 is stop-2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chr_we | input | 1 | Code register write strobe |
| chr_sel | input | 2 | Code index to write |
| chr_wdata | input | 8 | Code value |
| flow_en | input | 1 | Enable software flow control |
| dual_mode | input | 1 | Match on two consecutive characters |
| special_en | input | 1 | Special-character mode (overrides flow control) |
| irq_en | input | 1 | Interrupt enable for the flag |
| word_len | input | 2 | Character length: 0=5 bits through 3=8 bits |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| tx_busy | input | 1 | Transmitter is mid-character |
| fifo_count | input | CNT_W | Receive FIFO fill level |
| thr_hi | input | CNT_W | Level above which a stop code is requested |
| thr_lo | input | CNT_W | Level below which a resume code is requested |
| flag_clr | input | 1 | Clears the flag |
| tx_pause | output | 1 | Hold the transmitter |
| flag | output | 1 | Flow/special match status |
| irq | output | 1 | Interrupt |
| push_en | output | 1 | Write a character into the receive FIFO |
| push_data | output | 8 | Character to write |
| send_xoff | output | 1 | One-cycle request to transmit the stop code |
| send_xon | output | 1 | One-cycle request to transmit the resume code |

## Verification
On every cycle, the assertions check three things: the pause never starts while the transmitter is mid-character, the two send requests never coincide, and a push or a rise of the flag happens only when a character is being processed. The bench scenarios cover the rest. These include the drop/keep decision for each code, word-length masking, pair recognition and the replay after a broken pair, special mode, and the once-per-crossing threshold requests.

// File: rtl/xonxoff_flow_ctl.sv
module xonxoff_flow_ctl #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chr_we,
  input  logic [1:0]       chr_sel,
  input  logic [7:0]       chr_wdata,
  input  logic             flow_en,
  input  logic             dual_mode,
  input  logic             special_en,
  input  logic             irq_en,
  input  logic [1:0]       word_len,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             tx_busy,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic [CNT_W-1:0] thr_hi,
  input  logic [CNT_W-1:0] thr_lo,
  input  logic             flag_clr,
  output logic             tx_pause,
  output logic             flag,
  output logic             irq,
  output logic             push_en,
  output logic [7:0]       push_data,
  output logic             send_xoff,
  output logic             send_xon
);

  logic [7:0] on1, on2, off1, off2, mask, s_d, rep_d, hold_d;
  logic       rep_v, hold_v, hold_off, hold_tx, xoff_sent;
  logic       s_v, sw;
  logic       m_on1, m_on2, m_off1, m_off2;
  logic       xoff_hit, xon_hit, spec_hit, take, release_h;

  assign mask = 8'hFF >> (2'd3 - word_len);
  assign s_v  = rep_v | rx_valid;
  assign s_d  = rep_v ? rep_d : rx_data;
  assign sw   = flow_en & ~special_en;
  assign irq  = flag & irq_en;

  assign m_on1  = ((s_d ^ on1)  & mask) == 8'h00;
  assign m_on2  = ((s_d ^ on2)  & mask) == 8'h00;
  assign m_off1 = ((s_d ^ off1) & mask) == 8'h00;
  assign m_off2 = ((s_d ^ off2) & mask) == 8'h00;

  always_comb begin
    push_en   = 1'b0;
    push_data = s_d;
    xoff_hit  = 1'b0;
    xon_hit   = 1'b0;
    spec_hit  = 1'b0;
    take      = 1'b0;
    release_h = 1'b0;
    if (s_v) begin
      if (special_en) begin
        push_en  = 1'b1;
        spec_hit = m_off2;
      end else if (!sw) begin
        push_en = 1'b1;
      end else if (dual_mode) begin
        if (hold_v) begin
          if (hold_off && m_off2)       xoff_hit = 1'b1;
          else if (!hold_off && m_on2)  xon_hit  = 1'b1;
          else begin
            push_en   = 1'b1;
            push_data = hold_d;
            release_h = 1'b1;
          end
        end else if (m_off1 || m_on1) begin
          take = 1'b1;
        end else begin
          push_en = 1'b1;
        end
      end else begin
        if (m_off1)     xoff_hit = 1'b1;
        else if (m_on1) xon_hit  = 1'b1;
        else            push_en  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on1 <= '0; on2 <= '0; off1 <= '0; off2 <= '0;
    end else if (chr_we) begin
      case (chr_sel)
        2'd0: on1  <= chr_wdata;
        2'd1: on2  <= chr_wdata;
        2'd2: off1 <= chr_wdata;
        default: off2 <= chr_wdata;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep_v    <= 1'b0;
      rep_d    <= '0;
      hold_v   <= 1'b0;
      hold_d   <= '0;
      hold_off <= 1'b0;
    end else begin
      rep_v <= release_h;
      if (release_h) rep_d <= rx_data;
      if (!sw || !dual_mode) hold_v <= 1'b0;
      else if (take)         hold_v <= 1'b1;
      else if (s_v)          hold_v <= 1'b0;
      if (take) begin
        hold_d   <= s_d;
        hold_off <= m_off1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag     <= 1'b0;
      hold_tx  <= 1'b0;
      tx_pause <= 1'b0;
    end else begin
      if (xoff_hit || spec_hit)    flag <= 1'b1;
      else if (xon_hit || flag_clr) flag <= 1'b0;
      if (!sw)           hold_tx <= 1'b0;
      else if (xoff_hit) hold_tx <= 1'b1;
      else if (xon_hit)  hold_tx <= 1'b0;
      tx_pause <= hold_tx & (tx_pause | ~tx_busy);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xoff_sent <= 1'b0;
      send_xoff <= 1'b0;
      send_xon  <= 1'b0;
    end else if (!sw) begin
      xoff_sent <= 1'b0;
      send_xoff <= 1'b0;
      send_xon  <= 1'b0;
    end else begin
      send_xoff <= ~xoff_sent & (fifo_count > thr_hi);
      send_xon  <=  xoff_sent & (fifo_count < thr_lo);
      if (!xoff_sent && fifo_count > thr_hi)     xoff_sent <= 1'b1;
      else if (xoff_sent && fifo_count < thr_lo) xoff_sent <= 1'b0;
    end
  end

  assert_pause_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_pause) |-> $past(!tx_busy));

  assert_send_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({send_xoff, send_xon}));

  assert_rx_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_push_needs_char_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> (rx_valid || rep_v));

  assert_flag_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(rx_valid || rep_v));

endmodule

// File: tb/xonxoff_flow_ctl_bench.sv
module xonxoff_flow_ctl_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       chr_we = 0, flow_en = 0, dual_mode = 0, special_en = 0, irq_en = 0;
  logic [1:0] chr_sel = 0, word_len = 2'd3;
  logic [7:0] chr_wdata = 0, rx_data = 0;
  logic       rx_valid = 0, tx_busy = 0, flag_clr = 0;
  logic [7:0] fifo_count = 0, thr_hi = 8'd10, thr_lo = 8'd4;
  logic       tx_pause, flag, irq, push_en, send_xoff, send_xon;
  logic [7:0] push_data;
  int         n_chk = 0, n_fail = 0;
  logic       p0, p1;
  logic [7:0] pd0, pd1;

  always #2.5 clk = ~clk;

  xonxoff_flow_ctl u_xonxoff_flow_ctl (
    .clk(clk), .rst_n(rst_n), .chr_we(chr_we), .chr_sel(chr_sel), .chr_wdata(chr_wdata),
    .flow_en(flow_en), .dual_mode(dual_mode), .special_en(special_en), .irq_en(irq_en),
    .word_len(word_len), .rx_valid(rx_valid), .rx_data(rx_data), .tx_busy(tx_busy),
    .fifo_count(fifo_count), .thr_hi(thr_hi), .thr_lo(thr_lo), .flag_clr(flag_clr),
    .tx_pause(tx_pause), .flag(flag), .irq(irq), .push_en(push_en), .push_data(push_data),
    .send_xoff(send_xoff), .send_xon(send_xon));

  // data, expected push, expected flag afterwards (single mode, 8-bit, R1 R3 R4 R5)
  localparam logic [9:0] VEC [6] = '{
    {8'h41, 1'b1, 1'b0}, {8'h13, 1'b0, 1'b1}, {8'h42, 1'b1, 1'b1},
    {8'h11, 1'b0, 1'b0}, {8'h93, 1'b1, 1'b0}, {8'h7F, 1'b1, 1'b0}};

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); chr_we = 1; chr_sel = s; chr_wdata = d;
    @(negedge clk); chr_we = 0;
  endtask

  task automatic rx(input logic [7:0] d);
    @(negedge clk); rx_valid = 1; rx_data = d;
    #1 p0 = push_en; pd0 = push_data;
    @(negedge clk); rx_valid = 0;
    #1 p1 = push_en; pd1 = push_data;
    @(negedge clk);
  endtask

  task automatic count_pulses(input int n, output int nx, output int nn);
    nx = 0; nn = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      nx += int'(send_xoff);
      nn += int'(send_xon);
    end
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int nx, nn;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!tx_pause && !flag && !irq && !send_xoff && !send_xon, "reset", {tx_pause, flag, irq}, 0);

    // R11: codes are zero after reset, so 0x00 matches and is dropped
    flow_en = 1;
    rx(8'h00);
    chk(p0 == 0, "R11 zero code drop", p0, 0);
    chk(flag == 1, "R11 zero code flag", flag, 1);

    wr(2'd0, 8'h11); wr(2'd1, 8'h91); wr(2'd2, 8'h13); wr(2'd3, 8'h93);
    rx(8'h11);
    chk(flag == 0, "R3 resume clears flag", flag, 0);
    repeat (2) @(negedge clk);
    chk(tx_pause == 0, "R3 resume releases pause", tx_pause, 0);

    for (int i = 0; i < 6; i++) begin
      rx(VEC[i][9:2]);
      chk(p0 == VEC[i][1], "R1/R3/R4 table push", p0, VEC[i][1]);
      if (p0) chk(pd0 == VEC[i][9:2], "R4 table data", pd0, VEC[i][9:2]);
      chk(flag == VEC[i][0], "R1/R3 table flag", flag, VEC[i][0]);
    end

    // R2: pause waits for character boundary
    tx_busy = 1;
    rx(8'h13);
    repeat (3) @(negedge clk);
    chk(tx_pause == 0, "R2 no pause while busy", tx_pause, 0);
    tx_busy = 0;
    repeat (2) @(negedge clk);
    chk(tx_pause == 1, "R2 pause at boundary", tx_pause, 1);

    // R9 irq gating and clear
    chk(irq == 0, "R9 irq masked", irq, 0);
    irq_en = 1; #1;
    chk(irq == 1, "R9 irq enabled", irq, 1);
    @(negedge clk); flag_clr = 1; @(negedge clk); flag_clr = 0;
    chk(flag == 0 && irq == 0, "R9 flag clear", {flag, irq}, 0);
    irq_en = 0;
    rx(8'h11);
    repeat (2) @(negedge clk);
    chk(tx_pause == 0, "R3 resume after pause", tx_pause, 0);

    // R5: 5-bit word length masks upper bits
    word_len = 2'd0;
    rx(8'hF3);
    chk(p0 == 0 && flag == 1, "R5 masked match", {p0, flag}, 1);
    rx(8'hF1);
    chk(p0 == 0 && flag == 0, "R5 masked resume", {p0, flag}, 0);
    word_len = 2'd3;

    // R4: flow off passes everything
    flow_en = 0;
    rx(8'h13);
    chk(p0 == 1 && pd0 == 8'h13, "R4 flow off push", pd0, 8'h13);
    flow_en = 1;

    // R6/R7 dual mode
    dual_mode = 1;
    rx(8'h13);
    chk(p0 == 0, "R6 first held", p0, 0);
    rx(8'h55);
    chk(p0 == 1 && pd0 == 8'h13, "R7 held released", pd0, 8'h13);
    chk(p1 == 1 && pd1 == 8'h55, "R7 second replayed", pd1, 8'h55);
    chk(flag == 0, "R7 no match", flag, 0);
    rx(8'h13);
    rx(8'h13);
    chk(p0 == 1 && pd0 == 8'h13 && p1 == 0, "R7 recheck as first", {p0, p1}, 2);
    rx(8'h93);
    chk(p0 == 0 && flag == 1, "R6 pair stop", {p0, flag}, 1);
    repeat (2) @(negedge clk);
    chk(tx_pause == 1, "R6 pair pauses", tx_pause, 1);
    rx(8'h91);
    chk(p0 == 1 && pd0 == 8'h91 && flag == 1, "R6 order matters", {p0, flag}, 3);
    rx(8'h11);
    rx(8'h91);
    chk(p0 == 0 && flag == 0, "R6 pair resume", {p0, flag}, 0);
    dual_mode = 0;

    // R8 special mode
    special_en = 1;
    rx(8'h93);
    chk(p0 == 1 && pd0 == 8'h93, "R8 special pushed", pd0, 8'h93);
    chk(flag == 1, "R8 special flag", flag, 1);
    repeat (2) @(negedge clk);
    chk(tx_pause == 0, "R8 no pause", tx_pause, 0);
    rx(8'h13);
    chk(p0 == 1, "R8 other code pushed", p0, 1);
    special_en = 0;
    @(negedge clk); flag_clr = 1; @(negedge clk); flag_clr = 0;

    // R10 thresholds
    fifo_count = 8'd2;
    count_pulses(4, nx, nn);
    chk(nn == 0 && nx == 0, "R10 no resume before stop", nn, 0);
    fifo_count = 8'd11;
    count_pulses(6, nx, nn);
    chk(nx == 1, "R10 single stop request", nx, 1);
    fifo_count = 8'd7;
    count_pulses(4, nx, nn);
    chk(nx == 0 && nn == 0, "R10 hysteresis band", nx + nn, 0);
    fifo_count = 8'd3;
    count_pulses(6, nx, nn);
    chk(nn == 1 && nx == 0, "R10 single resume request", nn, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule